// File: doc/BRIEF.md
# External Pin Interrupt Unit

The block watches a vector of external pins and turns qualified level transitions into sticky per-channel event flags. Each channel can be armed for rising transitions, falling transitions, both or neither. An optional digital glitch filter can sit in front of the transition detector on each channel. The filter counts ticks from one prescaler shared by all channels. It accepts a new pin level only after that level has held for a per-channel number of ticks.

A set flag is held until software clears it by writing a one to its bit. A per-channel request enable gates the flag onto a request output. A per-channel route bit picks the request type. Channels routed to interrupt are ORed onto a single interrupt line. Channels routed to DMA drive their own bit of a DMA request vector. The configuration sits in a word-addressed register port with a combinational read path. A flag is set whether or not its request is enabled, so software can also poll the flags.

Top module: `pin_irq_unit`

## Requirements
- R1: Pins pass through a two-flop synchronizer. With the filter off, a 0-to-1 pin change on a channel whose rise-arm bit is set sets that channel's flag.
- R2: A 1-to-0 pin change on a channel whose fall-arm bit is set sets its flag. A channel with both arm bits set flags either direction.
- R3: A channel with neither arm bit set never sets its flag.
- R4: Writing the flag register (word 0) clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R5: A flag is set by a qualified transition even when the channel's request enable (word 1) is 0. In that case neither irq_o nor dma_req_o is raised.
- R6: Route bit (word 2) 1 sends the channel to DMA and 0 sends it to interrupt. dma_req_o[n] = flag & enable & route for channel n. irq_o is 1 when any channel has its flag and enable set and its route bit clear.
- R7: With the filter enabled (word 5), a new synchronized level is passed only after it differs from the filtered level on max+1 consecutive ticks, where max is the channel's count. A shorter excursion is discarded. With prescaler 0, a pulse of L cycles is passed exactly when L >= max+1.
- R8: The shared prescaler (word 6, PRESC_W bits) makes a tick every value+1 cycles. Rewriting it at run time changes the filter timing at once.
- R9: Each channel's maximum filter count lives at word 32+n and keeps only its low CNT_W bits on write.
- R10: When a new qualified transition and a clearing write of the same bit happen in the same cycle, the flag ends up set.
- R11: After reset every register and flag reads zero, and irq_o and dma_req_o are low.
- R12: The words are laid out as follows and read back what was written: 0 flags, 1 request enable, 2 route, 3 rise-arm, 4 fall-arm, 5 filter enable, 6 prescaler, and 32+n for the maximum count of channel n. Unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe for one cycle |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| pin_i | input | NUM_CH | External pins, asynchronous |
| irq_o | output | 1 | OR of the enabled flags of channels routed to interrupt |
| dma_req_o | output | NUM_CH | Per-channel DMA request |

## Verification
All pins are toggled together while the arm bits follow a four-way pattern across the channels. This tells rise-only, fall-only, both and none apart in a single pass. A walking single-pin toggle then shows that no channel flags on behalf of a neighbour. The filter is swept over pulse length against maximum count with the prescaler at zero, where the pass/drop boundary L >= max+1 is exact. Short and long pulses under a slow and then a rewritten prescaler separate the tick timing from the count. Routing is tried with enable/route pairs that split the same flag set between the interrupt line and the DMA vector. A clear that lands on the same edge as a new transition exposes the set-over-clear priority.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] REG_FLAG    = 6'd0;
  localparam logic [ADDR_W-1:0] REG_REQ_EN  = 6'd1;
  localparam logic [ADDR_W-1:0] REG_ROUTE   = 6'd2;
  localparam logic [ADDR_W-1:0] REG_RISE    = 6'd3;
  localparam logic [ADDR_W-1:0] REG_FALL    = 6'd4;
  localparam logic [ADDR_W-1:0] REG_FILT_EN = 6'd5;
  localparam logic [ADDR_W-1:0] REG_PRESC   = 6'd6;
  // max-count words start at 32, one per channel
  localparam int REG_MAX_BASE = 32;
endpackage

// File: rtl/pin_irq_prescaler.sv
module pin_irq_prescaler #(
  parameter int PRESC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  // >= so a lowered prescaler takes effect without wrapping
  assign tick_o = (cnt_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PRESC_W'(1);
  end
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             tick_i,
  input  logic             filt_en_i,
  input  logic [CNT_W-1:0] max_cnt_i,
  output logic             rise_o,
  output logic             fall_o
);
  logic [1:0]       sync_q;
  logic             lvl_q;
  logic             lvl_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             s_lvl;

  assign s_lvl = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!filt_en_i) begin
      lvl_q <= s_lvl;
      cnt_q <= '0;
    end else if (s_lvl == lvl_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == max_cnt_i) begin
        lvl_q <= s_lvl;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev_q <= 1'b0;
    else         lvl_prev_q <= lvl_q;
  end

  assign rise_o = lvl_q & ~lvl_prev_q;
  assign fall_o = ~lvl_q & lvl_prev_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int CNT_W   = 4,
  parameter int PRESC_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    we_i,
  input  logic [NUM_CH-1:0]       event_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [NUM_CH-1:0]       flag_o,
  output logic [NUM_CH-1:0]       req_en_o,
  output logic [NUM_CH-1:0]       route_o,
  output logic [NUM_CH-1:0]       rise_en_o,
  output logic [NUM_CH-1:0]       fall_en_o,
  output logic [NUM_CH-1:0]       filt_en_o,
  output logic [PRESC_W-1:0]      presc_o,
  output logic [NUM_CH*CNT_W-1:0] max_cnt_o
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0]  flag_q, req_en_q, route_q, rise_q, fall_q, filt_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   max_q [NUM_CH];
  logic [NUM_CH-1:0]  clr_mask;
  logic [IDX_W-1:0]   max_sel;

  assign clr_mask = (we_i && addr_i == REG_FLAG) ? wdata_i[NUM_CH-1:0] : '0;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_mask) | event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_en_q <= '0;
      route_q  <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      filt_q   <= '0;
      presc_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_REQ_EN:  req_en_q <= wdata_i[NUM_CH-1:0];
        REG_ROUTE:   route_q  <= wdata_i[NUM_CH-1:0];
        REG_RISE:    rise_q   <= wdata_i[NUM_CH-1:0];
        REG_FALL:    fall_q   <= wdata_i[NUM_CH-1:0];
        REG_FILT_EN: filt_q   <= wdata_i[NUM_CH-1:0];
        REG_PRESC:   presc_q  <= wdata_i[PRESC_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_max
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        max_q[ch] <= '0;
      else if (we_i && addr_i == ADDR_W'(REG_MAX_BASE + ch))
        max_q[ch] <= wdata_i[CNT_W-1:0];
    end
    assign max_cnt_o[ch*CNT_W +: CNT_W] = max_q[ch];
  end

  assign max_sel = addr_i[IDX_W-1:0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_FLAG:    rdata_o[NUM_CH-1:0]  = flag_q;
      REG_REQ_EN:  rdata_o[NUM_CH-1:0]  = req_en_q;
      REG_ROUTE:   rdata_o[NUM_CH-1:0]  = route_q;
      REG_RISE:    rdata_o[NUM_CH-1:0]  = rise_q;
      REG_FALL:    rdata_o[NUM_CH-1:0]  = fall_q;
      REG_FILT_EN: rdata_o[NUM_CH-1:0]  = filt_q;
      REG_PRESC:   rdata_o[PRESC_W-1:0] = presc_q;
      default: begin
        if (addr_i[ADDR_W-1] && int'(max_sel) < NUM_CH)
          rdata_o[CNT_W-1:0] = max_q[max_sel];
      end
    endcase
  end

  assign flag_o    = flag_q;
  assign req_en_o  = req_en_q;
  assign route_o   = route_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign filt_en_o = filt_q;
  assign presc_o   = presc_q;
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int CNT_W   = 4,
  parameter int PRESC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_we_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] pin_i,
  output logic              irq_o,
  output logic [NUM_CH-1:0] dma_req_o
);
  logic [NUM_CH-1:0]       flag, req_en, route, rise_en, fall_en, filt_en;
  logic [NUM_CH-1:0]       rise, fall, evt;
  logic [PRESC_W-1:0]      presc;
  logic [NUM_CH*CNT_W-1:0] max_cnt;
  logic                    tick;

  pin_irq_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .we_i      (reg_we_i),
    .event_i   (evt),
    .rdata_o   (reg_rdata_o),
    .flag_o    (flag),
    .req_en_o  (req_en),
    .route_o   (route),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .filt_en_o (filt_en),
    .presc_o   (presc),
    .max_cnt_o (max_cnt)
  );

  pin_irq_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .presc_i (presc),
    .tick_o  (tick)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pin_irq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (pin_i[ch]),
      .tick_i    (tick),
      .filt_en_i (filt_en[ch]),
      .max_cnt_i (max_cnt[ch*CNT_W +: CNT_W]),
      .rise_o    (rise[ch]),
      .fall_o    (fall[ch])
    );
  end

  assign evt       = (rise & rise_en) | (fall & fall_en);
  assign irq_o     = |(flag & req_en & ~route);
  assign dma_req_o = flag & req_en & route;
endmodule

// File: rtl/pin_irq_unit_chk.sv
module pin_irq_unit_chk #(
  parameter int NUM_CH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [5:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              reg_we_i,
  input logic              irq_o,
  input logic [NUM_CH-1:0] dma_req_o,
  input logic [NUM_CH-1:0] flag,
  input logic [NUM_CH-1:0] req_en,
  input logic [NUM_CH-1:0] route,
  input logic [NUM_CH-1:0] edge_en
);
  logic [NUM_CH-1:0] clr_mask;
  assign clr_mask = (reg_we_i && reg_addr_i == 6'd0) ? reg_wdata_i[NUM_CH-1:0] : '0;

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((($past(flag) & ~$past(clr_mask)) & ~flag)) == '0));

  // R3
  unarmed_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag & ~$past(flag) & ~$past(edge_en)) == '0));

  // R6
  dma_routed_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dma_req_o & ~(route & req_en)) == '0));

  // R6
  irq_needs_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flag & req_en & ~route) != '0));

  // R5
  no_req_without_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_en == '0) |-> (!irq_o && dma_req_o == '0));
endmodule

bind pin_irq_unit pin_irq_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_we_i    (reg_we_i),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o),
  .flag        (flag),
  .req_en      (req_en),
  .route       (route),
  .edge_en     (rise_en | fall_en)
);

// File: tb/pin_irq_unit_bench.sv
module pin_irq_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        irq;
  logic [31:0] dma;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  pin_irq_unit u_pin_irq_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .pin_i(pins), .irq_o(irq), .dma_req_o(dma)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i); addr = a; wdata = d; we = 1'b1;
    @(negedge clk_i); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk_i); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse5(input int len);
    @(negedge clk_i); pins[5] = 1'b1;
    idle(len);
    pins[5] = 1'b0;
    idle(24);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] en_tab [5];
    logic [31:0] rt_tab [5];
    logic [31:0] rise_m, fall_m;
    en_tab = '{32'hFFFF_FFFF, 32'h00FF_00FF, 32'h0, 32'hF0F0_F0F0, 32'hFFFF_FFFF};
    rt_tab = '{32'h0, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0};
    rise_m = 32'hAAAA_AAAA;
    fall_m = 32'hCCCC_CCCC;

    idle(4);
    rst_ni = 1'b1;
    idle(2);

    // R11 reset state
    for (int a = 0; a < 7; a++) rd_chk("R11 reg", 6'(a), 32'h0);
    rd_chk("R11 maxcnt0", 6'd32, 32'h0);
    rd_chk("R11 maxcnt31", 6'd63, 32'h0);
    chk("R11 irq", {31'b0, irq}, 32'h0);
    chk("R11 dma", dma, 32'h0);

    // R12 layout and readback
    wr(6'd1, 32'h1234_5678); wr(6'd2, 32'h9ABC_DEF0); wr(6'd5, 32'h0F0F_00FF);
    rd_chk("R12 req_en", 6'd1, 32'h1234_5678);
    rd_chk("R12 route", 6'd2, 32'h9ABC_DEF0);
    rd_chk("R12 filt_en", 6'd5, 32'h0F0F_00FF);
    rd_chk("R12 unmapped", 6'd7, 32'h0);
    wr(6'd1, 32'h0); wr(6'd2, 32'h0); wr(6'd5, 32'h0);

    // R9 masking, R12 per-channel words
    for (int ch = 0; ch < 32; ch++) wr(6'(32 + ch), 32'h5A5A_5A50 | 32'(ch));
    for (int ch = 0; ch < 32; ch++) rd_chk("R9 maxcnt", 6'(32 + ch), 32'(ch & 15));

    // R1 R2 R3 R5 all pins together
    wr(6'd3, rise_m); wr(6'd4, fall_m);
    @(negedge clk_i); pins = '1;
    idle(8);
    rd_chk("R1 rise flags", 6'd0, rise_m);
    chk("R5 irq with enable off", {31'b0, irq}, 32'h0);
    chk("R5 dma with enable off", dma, 32'h0);
    wr(6'd0, 32'hFFFF_FFFF);
    rd_chk("R4 clear all", 6'd0, 32'h0);
    @(negedge clk_i); pins = '0;
    idle(8);
    rd_chk("R2 fall flags", 6'd0, fall_m);
    rd_chk("R3 unarmed", 6'd0, fall_m & ~32'h1111_1111);

    // R4 write zero and partial clear
    wr(6'd0, 32'h0);
    rd_chk("R4 write zero", 6'd0, fall_m);
    wr(6'd0, 32'h0000_FFFF);
    rd_chk("R4 partial", 6'd0, fall_m & 32'hFFFF_0000);

    // R1 R2 R3 walking single pin
    for (int ch = 0; ch < 32; ch++) begin
      wr(6'd0, 32'hFFFF_FFFF);
      @(negedge clk_i); pins[ch] = 1'b1;
      idle(6);
      pins[ch] = 1'b0;
      idle(6);
      rd_chk("R2 walk", 6'd0, ((rise_m | fall_m) & (32'h1 << ch)));
    end

    // R6 routing
    wr(6'd3, 32'hFFFF_FFFF);
    @(negedge clk_i); pins = '1;
    idle(8);
    for (int k = 0; k < 5; k++) begin
      if (k == 4) wr(6'd0, 32'hFFFF_FFFF);
      wr(6'd1, en_tab[k]); wr(6'd2, rt_tab[k]);
      idle(1);
      chk("R6 irq", {31'b0, irq},
          {31'b0, |((k == 4 ? 32'h0 : 32'hFFFF_FFFF) & en_tab[k] & ~rt_tab[k])});
      chk("R6 dma", dma, (k == 4 ? 32'h0 : 32'hFFFF_FFFF) & en_tab[k] & rt_tab[k]);
    end
    @(negedge clk_i); pins = '0;
    idle(8);
    wr(6'd1, 32'h0); wr(6'd2, 32'h0);

    // R7 filter sweep, prescaler 0, channel 5 rise only
    wr(6'd3, 32'h20); wr(6'd4, 32'h0); wr(6'd5, 32'h20); wr(6'd6, 32'h0);
    wr(6'd0, 32'hFFFF_FFFF);
    for (int m = 0; m < 5; m++) begin
      wr(6'd37, 32'(m));
      for (int len = 1; len < 7; len++) begin
        wr(6'd0, 32'hFFFF_FFFF);
        pulse5(len);
        rd_chk("R7 filter", 6'd0, (len >= m + 1) ? 32'h20 : 32'h0);
      end
    end

    // R8 prescaler 3 with max 1 needs two ticks four cycles apart
    wr(6'd37, 32'd1); wr(6'd6, 32'd3);
    wr(6'd0, 32'hFFFF_FFFF);
    pulse5(3);
    rd_chk("R8 short pulse slow tick", 6'd0, 32'h0);
    pulse5(12);
    rd_chk("R8 long pulse slow tick", 6'd0, 32'h20);
    wr(6'd6, 32'd0);
    wr(6'd0, 32'hFFFF_FFFF);
    pulse5(3);
    rd_chk("R8 short pulse after rewrite", 6'd0, 32'h20);

    // R10 set and clear on the same edge
    wr(6'd5, 32'h0);
    wr(6'd0, 32'hFFFF_FFFF);
    idle(4);
    @(negedge clk_i); pins[5] = 1'b1;
    repeat (3) @(negedge clk_i);
    addr = 6'd0; wdata = 32'hFFFF_FFFF; we = 1'b1;
    @(negedge clk_i); we = 1'b0;
    rd_chk("R10 set wins", 6'd0, 32'h20);
    wr(6'd0, 32'hFFFF_FFFF);
    rd_chk("R10 later clear", 6'd0, 32'h0);

    finish_run();
  end
endmodule